// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Level Thresholds

This block sits between a system-side register port and a PCM serializer. It holds two 32-bit sample queues. The transmit queue is filled by system writes and drained by the serializer. The receive queue is filled by the serializer and drained by system reads. Four level comparators drive the DMA request and DMA panic lines for each direction. Each comparator uses its own programmable threshold, so a DMA engine can run at normal pace and speed up when a queue is close to running dry (transmit) or close to overflowing (receive).

The serializer side runs on bit-clock cycles, which reach the block as a one-cycle strobe `bitTick` in the system clock domain. Three actions count bit-clock cycles rather than system cycles:
- **Queue clear:** takes effect on the second tick after it is requested.
- **Echo bit:** a value written to it reads back after two ticks, which lets software check that the bit clock is running.
- **Standby wake-up:** the serializer side stays idle until four ticks after the wake-up bit is set.

Underflow and overflow set sticky error flags, and a masked OR of the error and level flags drives one interrupt line.

Registers, by `regAddr`: 0 = control/status, 1 = sample data, 2 = thresholds, 3 = interrupt enables.

Top module: `audfifo_top`

## Requirements
- R1: Each queue holds up to 64 words and delivers them first-in first-out. A write to address 1 appends to the transmit queue. A read from address 1 returns and removes the oldest receive word. A push to a full queue is dropped, and a pop from an empty queue changes nothing.
- R2: While control bit 0 (enable) is 1, `dmaTxReq` is high when the transmit level is less than or equal to threshold field [14:8], and `dmaTxPanic` is high when the level is less than or equal to field [30:24]. Both are low while enable is 0.
- R3: While enable is 1, `dmaRxReq` is high when the receive level is greater than field [6:0], and `dmaRxPanic` is high when the level is greater than field [22:16]. Both are low while enable is 0.
- R4: Address 2 holds the four 7-bit thresholds at the positions named in R2 and R3 and reads back what was written. Its reset value is 0x10303020.
- R5: Status bits in the control word:
  - 22: receive queue full
  - 21: transmit queue empty
  - 20: receive queue holds data
  - 19: transmit queue has space
  - 18: receive level is above its request threshold
  - 17: transmit level is at or below its request threshold
- R6: Writing 1 to control bit 3 (transmit) or bit 4 (receive) empties that queue on the second `bitTick` after the write. The bit reads 1 while the clear is pending.
- R7: Control bit 24 reads back the value last written to it, but only after two `bitTick` pulses.
- R8: Control bit 25 is the wake-up bit. Serializer pops (`serTxReq`) and pushes (`serRxValid`) are ignored unless bit 0 is 1 and four `bitTick` pulses have passed since bit 25 went from 0 to 1.
- R9: Transmit error (bit 15) is set by a system write to a full transmit queue or by a serializer pop of an empty one. Receive error (bit 16) is set by a serializer push to a full receive queue or by a system read of an empty one. Both stay set until 1 is written to them.
- R10: A read from address 1 while the receive queue is empty returns the last word read from it (0 after reset).
- R11: Address 3 holds four interrupt enables: bit 3 receive error, bit 2 transmit error, bit 1 the R5 bit 18 flag, bit 0 the R5 bit 17 flag. `irq` is the OR of each enabled flag.
- R12: `serTxData` shows the oldest transmit word, or 0 while the transmit queue is empty.
- R13: After reset both queues are empty, enable, wake-up, echo, clear and error bits are 0, the interrupt enables are 0, and the control word reads 0x002A0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle strobe per serializer bit-clock cycle |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (removes a receive word at address 1) |
| regAddr | input | 2 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from `regAddr` |
| serTxReq | input | 1 | Serializer takes the oldest transmit word |
| serTxData | output | 32 | Oldest transmit word |
| serRxValid | input | 1 | Serializer delivers a receive word |
| serRxData | input | 32 | Receive word from the serializer |
| dmaTxReq | output | 1 | Transmit DMA request |
| dmaTxPanic | output | 1 | Transmit DMA panic |
| dmaRxReq | output | 1 | Receive DMA request |
| dmaRxPanic | output | 1 | Receive DMA panic |
| irq | output | 1 | Interrupt request |

## Verification
The queues are driven by random traffic in four biased phases:
- **Transmit fill:** walks the transmit level up through the panic and request thresholds.
- **Drain:** brings the level back down through those thresholds.
- **Balanced:** mixes pushes and pops in the same cycle, which separates a correct simultaneous update from a wrong one.
- **Saturating:** pins both queues at full, so dropped pushes and sticky errors show up.

Directed sequences cover the rest:
- a low threshold setting, stepped one word at a time, to find off-by-one comparator errors;
- tick-by-tick reads during a clear, the echo bit and the standby wake-up, to catch a wrong tick count;
- reads of an empty receive queue, to show the word that is returned and the error that is flagged.

// File: rtl/audfifo_pkg.sv
`timescale 1ns/1ps
package audfifo_pkg;
  localparam int LVL_W     = 7;
  localparam int BIT_EN    = 0;
  localparam int BIT_TXCLR = 3;
  localparam int BIT_RXCLR = 4;
  localparam int BIT_TXERR = 15;
  localparam int BIT_RXERR = 16;
  localparam int BIT_TXW   = 17;
  localparam int BIT_RXR   = 18;
  localparam int BIT_TXD   = 19;
  localparam int BIT_RXD   = 20;
  localparam int BIT_TXE   = 21;
  localparam int BIT_RXF   = 22;
  localparam int BIT_SYNC  = 24;
  localparam int BIT_STBY  = 25;

  localparam logic [LVL_W-1:0] RST_TX_PANIC = 7'h10;
  localparam logic [LVL_W-1:0] RST_RX_PANIC = 7'h30;
  localparam logic [LVL_W-1:0] RST_TX_REQ   = 7'h30;
  localparam logic [LVL_W-1:0] RST_RX_REQ   = 7'h20;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_DATA  = 2'd1,
    REG_LEVEL = 2'd2,
    REG_IRQEN = 2'd3
  } regSel_e;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/audfifo_ring.sv
`timescale 1ns/1ps
module audfifo_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic [W-1:0]                 pushData,
  input  logic                         pop,
  input  logic                         flush,
  output logic [W-1:0]                 headData,
  output logic [$clog2(DEPTH):0]       level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;
  logic          pushOk, popOk;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign pushOk   = push && !full;
  assign popOk    = pop && !empty;
  assign headData = mem[rdPtr];
  assign level    = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= pushData;
  end

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);

  // R1
  push_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !full && !flush) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/audfifo_dp.sv
`timescale 1ns/1ps
module audfifo_dp
  import audfifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoStrobes_t           strobes,
  input  logic [W-1:0]           sysWdata,
  input  logic [W-1:0]           serRxData,
  output logic [W-1:0]           serTxData,
  output logic [W-1:0]           sysRdWord,
  output logic [$clog2(DEPTH):0] txLevel,
  output logic [$clog2(DEPTH):0] rxLevel,
  output logic                   txFull,
  output logic                   txEmpty,
  output logic                   rxFull,
  output logic                   rxEmpty
);
  logic [W-1:0] txHead, rxHead, lastRd;

  audfifo_ring #(.W(W), .DEPTH(DEPTH)) txRing_i (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .pushData(sysWdata),
    .pop(strobes.txPop), .flush(strobes.txFlush),
    .headData(txHead), .level(txLevel), .full(txFull), .empty(txEmpty)
  );

  audfifo_ring #(.W(W), .DEPTH(DEPTH)) rxRing_i (
    .clk(clk), .rstN(rstN),
    .push(strobes.rxPush), .pushData(serRxData),
    .pop(strobes.rxPop), .flush(strobes.rxFlush),
    .headData(rxHead), .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            lastRd <= '0;
    else if (strobes.rxPop && !rxEmpty)   lastRd <= rxHead;
  end

  assign serTxData = txEmpty ? '0 : txHead;
  assign sysRdWord = rxEmpty ? lastRd : rxHead;
endmodule

// File: rtl/audfifo_ctrl.sv
`timescale 1ns/1ps
module audfifo_ctrl
  import audfifo_pkg::*;
#(
  parameter int W            = 32,
  parameter int DEPTH        = 64,
  parameter int SETTLE_TICKS = 4,
  parameter int CLEAR_TICKS  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bitTick,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [1:0]             regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic                   serTxReq,
  input  logic                   serRxValid,
  input  logic [$clog2(DEPTH):0] txLevel,
  input  logic [$clog2(DEPTH):0] rxLevel,
  input  logic                   txFull,
  input  logic                   txEmpty,
  input  logic                   rxFull,
  input  logic                   rxEmpty,
  input  logic [W-1:0]           sysRdWord,
  output fifoStrobes_t           strobes,
  output logic                   dmaTxReq,
  output logic                   dmaTxPanic,
  output logic                   dmaRxReq,
  output logic                   dmaRxPanic,
  output logic                   irq
);
  localparam int SETTLE_W = $clog2(SETTLE_TICKS + 1);
  localparam int CLR_W    = $clog2(CLEAR_TICKS + 1);

  logic                enQ, standbyQ, syncWr, syncMid, syncRd;
  logic                txErrQ, rxErrQ;
  logic [SETTLE_W-1:0] settleCnt;
  logic [CLR_W-1:0]    txClrCnt, rxClrCnt;
  logic [LVL_W-1:0]    txPanicLvl, rxPanicLvl, txReqLvl, rxReqLvl;
  logic [3:0]          irqEnQ;
  logic                ready, active, wrCtl, wrLvl, wrIrq;
  logic                txw, rxr, txErrSet, rxErrSet;
  logic [31:0]         statusWord;
  logic                unusedWd;

  assign unusedWd = ^{regWdata[31], regWdata[23], regWdata[7]};

  assign wrCtl  = regWrEn && (regAddr == REG_CTRL);
  assign wrLvl  = regWrEn && (regAddr == REG_LEVEL);
  assign wrIrq  = regWrEn && (regAddr == REG_IRQEN);
  assign ready  = standbyQ && (settleCnt == SETTLE_W'(SETTLE_TICKS));
  assign active = enQ && ready;

  always_comb begin
    strobes.txPush  = regWrEn && (regAddr == REG_DATA);
    strobes.rxPop   = regRdEn && (regAddr == REG_DATA);
    strobes.txPop   = serTxReq && active;
    strobes.rxPush  = serRxValid && active;
    strobes.txFlush = bitTick && (txClrCnt == CLR_W'(1));
    strobes.rxFlush = bitTick && (rxClrCnt == CLR_W'(1));
  end

  assign txErrSet = (strobes.txPush && txFull) || (strobes.txPop && txEmpty);
  assign rxErrSet = (strobes.rxPush && rxFull) || (strobes.rxPop && rxEmpty);

  assign txw = 32'(txLevel) <= 32'(txReqLvl);
  assign rxr = 32'(rxLevel) >  32'(rxReqLvl);

  assign dmaTxReq   = enQ && txw;
  assign dmaTxPanic = enQ && (32'(txLevel) <= 32'(txPanicLvl));
  assign dmaRxReq   = enQ && rxr;
  assign dmaRxPanic = enQ && (32'(rxLevel) > 32'(rxPanicLvl));
  assign irq        = |(irqEnQ & {rxErrQ, txErrQ, rxr, txw});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      standbyQ   <= 1'b0;
      syncWr     <= 1'b0;
      syncMid    <= 1'b0;
      syncRd     <= 1'b0;
      settleCnt  <= '0;
      txClrCnt   <= '0;
      rxClrCnt   <= '0;
      txErrQ     <= 1'b0;
      rxErrQ     <= 1'b0;
      txPanicLvl <= RST_TX_PANIC;
      rxPanicLvl <= RST_RX_PANIC;
      txReqLvl   <= RST_TX_REQ;
      rxReqLvl   <= RST_RX_REQ;
      irqEnQ     <= '0;
    end else begin
      if (wrCtl) begin
        enQ      <= regWdata[BIT_EN];
        standbyQ <= regWdata[BIT_STBY];
        syncWr   <= regWdata[BIT_SYNC];
      end
      if (wrCtl && (!regWdata[BIT_STBY] || !standbyQ))
        settleCnt <= '0;
      else if (bitTick && standbyQ && (settleCnt != SETTLE_W'(SETTLE_TICKS)))
        settleCnt <= settleCnt + 1'b1;
      if (bitTick) begin
        syncMid <= syncWr;
        syncRd  <= syncMid;
      end
      if (wrCtl && regWdata[BIT_TXCLR])   txClrCnt <= CLR_W'(CLEAR_TICKS);
      else if (bitTick && txClrCnt != '0) txClrCnt <= txClrCnt - 1'b1;
      if (wrCtl && regWdata[BIT_RXCLR])   rxClrCnt <= CLR_W'(CLEAR_TICKS);
      else if (bitTick && rxClrCnt != '0) rxClrCnt <= rxClrCnt - 1'b1;
      txErrQ <= txErrSet | (txErrQ & ~(wrCtl & regWdata[BIT_TXERR]));
      rxErrQ <= rxErrSet | (rxErrQ & ~(wrCtl & regWdata[BIT_RXERR]));
      if (wrLvl) begin
        txPanicLvl <= regWdata[30:24];
        rxPanicLvl <= regWdata[22:16];
        txReqLvl   <= regWdata[14:8];
        rxReqLvl   <= regWdata[6:0];
      end
      if (wrIrq) irqEnQ <= regWdata[3:0];
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[BIT_EN]    = enQ;
    statusWord[BIT_TXCLR] = (txClrCnt != '0);
    statusWord[BIT_RXCLR] = (rxClrCnt != '0);
    statusWord[BIT_TXERR] = txErrQ;
    statusWord[BIT_RXERR] = rxErrQ;
    statusWord[BIT_TXW]   = txw;
    statusWord[BIT_RXR]   = rxr;
    statusWord[BIT_TXD]   = !txFull;
    statusWord[BIT_RXD]   = !rxEmpty;
    statusWord[BIT_TXE]   = txEmpty;
    statusWord[BIT_RXF]   = rxFull;
    statusWord[BIT_SYNC]  = syncRd;
    statusWord[BIT_STBY]  = standbyQ;
  end

  always_comb begin
    case (regAddr)
      REG_CTRL:  regRdata = statusWord;
      REG_DATA:  regRdata = 32'(sysRdWord);
      REG_LEVEL: regRdata = {1'b0, txPanicLvl, 1'b0, rxPanicLvl, 1'b0, txReqLvl, 1'b0, rxReqLvl};
      default:   regRdata = {28'd0, irqEnQ};
    endcase
  end

  // R7
  sync_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(syncRd));

  // R8
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(bitTick));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txErrQ && !(wrCtl && regWdata[BIT_TXERR])) |=> txErrQ);

  // R6
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txClrCnt == '0 && !(wrCtl && regWdata[BIT_TXCLR])) |=> (txClrCnt == '0));
endmodule

// File: rtl/audfifo_top.sv
`timescale 1ns/1ps
module audfifo_top
  import audfifo_pkg::*;
#(
  parameter int W            = 32,
  parameter int DEPTH        = 64,
  parameter int SETTLE_TICKS = 4,
  parameter int CLEAR_TICKS  = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitTick,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [1:0]    regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  logic          serTxReq,
  output logic [W-1:0]  serTxData,
  input  logic          serRxValid,
  input  logic [W-1:0]  serRxData,
  output logic          dmaTxReq,
  output logic          dmaTxPanic,
  output logic          dmaRxReq,
  output logic          dmaRxPanic,
  output logic          irq
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoStrobes_t     strobes;
  logic [W-1:0]     sysRdWord;
  logic [CNT_W-1:0] txLevel, rxLevel;
  logic             txFull, txEmpty, rxFull, rxEmpty;

  audfifo_ctrl #(.W(W), .DEPTH(DEPTH), .SETTLE_TICKS(SETTLE_TICKS),
                 .CLEAR_TICKS(CLEAR_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .serTxReq(serTxReq), .serRxValid(serRxValid),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .sysRdWord(sysRdWord), .strobes(strobes),
    .dmaTxReq(dmaTxReq), .dmaTxPanic(dmaTxPanic),
    .dmaRxReq(dmaRxReq), .dmaRxPanic(dmaRxPanic), .irq(irq)
  );

  audfifo_dp #(.W(W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .sysWdata(regWdata[W-1:0]), .serRxData(serRxData),
    .serTxData(serTxData), .sysRdWord(sysRdWord),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );
endmodule

// File: tb/audfifo_top_tb_top.sv
`timescale 1ns/1ps
module audfifo_top_tb_top;
  localparam int DEPTH = 64;
  localparam logic [31:0] BASE = 32'h0200_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        serTxReq = 1'b0, serRxValid = 1'b0;
  logic [31:0] serTxData, serRxData = '0;
  logic        dmaTxReq, dmaTxPanic, dmaRxReq, dmaRxPanic, irq;

  int nChecks = 0, nErr = 0;

  logic [31:0] txQ[$];
  logic [31:0] rxQ[$];
  logic [31:0] lastRdM = '0;
  bit enM = 0, stbyM = 0, syncWM = 0, syncMidM = 0, syncRdM = 0;
  bit txErrM = 0, rxErrM = 0;
  int settleM = 0, txPend = 0, rxPend = 0;
  int txPanicL = 'h10, rxPanicL = 'h30, txReqL = 'h30, rxReqL = 'h20;
  logic [3:0] irqEnM = '0;

  always #2.5 clk = ~clk;

  audfifo_top dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .serTxReq(serTxReq), .serTxData(serTxData),
    .serRxValid(serRxValid), .serRxData(serRxData),
    .dmaTxReq(dmaTxReq), .dmaTxPanic(dmaTxPanic),
    .dmaRxReq(dmaRxReq), .dmaRxPanic(dmaRxPanic), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[0]  = enM;
    s[3]  = txPend != 0;
    s[4]  = rxPend != 0;
    s[15] = txErrM;
    s[16] = rxErrM;
    s[17] = txQ.size() <= txReqL;
    s[18] = rxQ.size() > rxReqL;
    s[19] = txQ.size() < DEPTH;
    s[20] = rxQ.size() > 0;
    s[21] = txQ.size() == 0;
    s[22] = rxQ.size() == DEPTH;
    s[24] = syncRdM;
    s[25] = stbyM;
    return s;
  endfunction

  task automatic checkOuts();
    bit txw = txQ.size() <= txReqL;
    bit rxr = rxQ.size() > rxReqL;
    check("R2 dmaTxReq", 32'(dmaTxReq), 32'(enM && txw));
    check("R2 dmaTxPanic", 32'(dmaTxPanic), 32'(enM && (txQ.size() <= txPanicL)));
    check("R3 dmaRxReq", 32'(dmaRxReq), 32'(enM && rxr));
    check("R3 dmaRxPanic", 32'(dmaRxPanic), 32'(enM && (rxQ.size() > rxPanicL)));
    check("R12 serTxData", serTxData, txQ.size() > 0 ? txQ[0] : 32'd0);
    check("R11 irq", 32'(irq), 32'(|(irqEnM & {rxErrM, txErrM, rxr, txw})));
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, logic [31:0] exp, string tag);
    regAddr = a; regRdEn = 1'b1;
    #1 check(tag, regRdata, exp);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic wrCtl(logic [31:0] d);
    regWrite(2'd0, d);
    enM = d[0];
    if (!d[25] || !stbyM) settleM = 0;
    stbyM = d[25];
    syncWM = d[24];
    if (d[3]) txPend = 2;
    if (d[4]) rxPend = 2;
    if (d[15]) txErrM = 0;
    if (d[16]) rxErrM = 0;
    checkOuts();
  endtask

  task automatic tick();
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
    if (stbyM && settleM < 4) settleM++;
    syncRdM = syncMidM;
    syncMidM = syncWM;
    if (txPend > 0) begin txPend--; if (txPend == 0) txQ.delete(); end
    if (rxPend > 0) begin rxPend--; if (rxPend == 0) rxQ.delete(); end
  endtask

  task automatic step(int op, bit sp, bit sr, logic [31:0] wd, logic [31:0] rd);
    bit act = enM && stbyM && settleM >= 4;
    logic [31:0] expRd = rxQ.size() > 0 ? rxQ[0] : lastRdM;
    int ts = txQ.size();
    int rs = rxQ.size();
    regAddr = 2'd1; regWdata = wd;
    regWrEn = (op == 1); regRdEn = (op == 2);
    serTxReq = sp; serRxValid = sr; serRxData = rd;
    #1 if (op == 2) check("R1 R10 read data", regRdata, expRd);
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0; serTxReq = 1'b0; serRxValid = 1'b0;
    if (op == 1 && ts == DEPTH) txErrM = 1;
    if (sp && act && ts == 0) txErrM = 1;
    if (sp && act && ts > 0) void'(txQ.pop_front());
    if (op == 1 && ts < DEPTH) txQ.push_back(wd);
    if (sr && act && rs == DEPTH) rxErrM = 1;
    if (op == 2 && rs == 0) rxErrM = 1;
    if (op == 2 && rs > 0) lastRdM = rxQ.pop_front();
    if (sr && act && rs < DEPTH) rxQ.push_back(rd);
    checkOuts();
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R13 reset state, R4 threshold reset value
    regRead(2'd0, 32'h002A_0000, "R13 R5 reset status");
    regRead(2'd2, 32'h1030_3020, "R4 reset thresholds");
    regRead(2'd3, 32'h0, "R11 R13 reset irq enables");
    checkOuts();

    // R1 R12: load transmit queue before enabling
    step(1, 0, 0, 32'h1111_0001, 0);
    step(1, 0, 0, 32'h1111_0002, 0);
    step(1, 0, 0, 32'h1111_0003, 0);

    // R8 standby settle
    wrCtl(BASE);
    repeat (3) tick();
    step(0, 1, 1, 0, 32'hAAAA_0001);
    regRead(2'd0, expStatus(), "R8 serializer ignored before settle");
    tick();
    step(0, 1, 1, 0, 32'hAAAA_0002);
    regRead(2'd0, expStatus(), "R8 serializer active after settle");

    // R10 R9 empty read
    step(2, 0, 0, 0, 0);
    step(2, 0, 0, 0, 0);
    regRead(2'd0, expStatus(), "R9 receive error sticky");
    wrCtl(BASE | 32'h0001_0000);
    regRead(2'd0, expStatus(), "R9 receive error cleared");

    // R7 sync echo
    wrCtl(BASE | 32'h0100_0000);
    regRead(2'd0, expStatus(), "R7 echo before ticks");
    tick();
    regRead(2'd0, expStatus(), "R7 echo after one tick");
    tick();
    regRead(2'd0, expStatus(), "R7 echo after two ticks");
    wrCtl(BASE);
    tick(); tick();
    regRead(2'd0, expStatus(), "R7 echo returns low");

    // R6 delayed clear
    step(1, 0, 1, 32'h2222_0001, 32'hBBBB_0001);
    step(1, 0, 1, 32'h2222_0002, 32'hBBBB_0002);
    wrCtl(BASE | 32'h18);
    regRead(2'd0, expStatus(), "R6 clear pending");
    tick();
    regRead(2'd0, expStatus(), "R6 clear after one tick");
    tick();
    regRead(2'd0, expStatus(), "R6 clear after two ticks");
    checkOuts();

    // R2 R3 R4 threshold boundaries
    regWrite(2'd2, 32'h0003_0201);
    txPanicL = 0; rxPanicL = 3; txReqL = 2; rxReqL = 1;
    regRead(2'd2, 32'h0003_0201, "R4 threshold readback");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 32'h3333_0000 + i, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 32'hCCCC_0000 + i);
    for (int i = 0; i < 4; i++) step(2, 1, 0, 0, 0);

    // R11 interrupt from transmit underflow
    regWrite(2'd3, 32'h4);
    irqEnM = 4'h4;
    regRead(2'd3, 32'h4, "R11 enable readback");
    step(0, 1, 0, 0, 0);
    regRead(2'd0, expStatus(), "R9 transmit underflow");
    wrCtl(BASE | 32'h0000_8000);

    // random traffic
    regWrite(2'd2, 32'h1030_3020);
    txPanicL = 'h10; rxPanicL = 'h30; txReqL = 'h30; rxReqL = 'h20;
    regWrite(2'd3, 32'h3);
    irqEnM = 4'h3;
    for (int ph = 0; ph < 4; ph++) begin
      int wrP, rdP, popP, pushP;
      case (ph)
        0: begin wrP = 80; rdP = 10; popP = 10; pushP = 70; end
        1: begin wrP = 10; rdP = 60; popP = 60; pushP = 10; end
        2: begin wrP = 45; rdP = 45; popP = 50; pushP = 50; end
        default: begin wrP = 90; rdP = 0; popP = 0; pushP = 95; end
      endcase
      for (int n = 0; n < 200; n++) begin
        int r = $urandom % 100;
        int op = (r < wrP) ? 1 : (r < wrP + rdP) ? 2 : 0;
        step(op, ($urandom % 100) < popP, ($urandom % 100) < pushP,
             $urandom, $urandom);
        if (n % 50 == 49) regRead(2'd0, expStatus(), "R5 R9 status random");
      end
    end

    // R8 disable drops requests and ignores the serializer
    wrCtl(32'h0200_0000);
    step(0, 1, 1, 0, 32'hDDDD_0001);
    regRead(2'd0, expStatus(), "R8 disabled status");

    finishRun();
  end
endmodule